// File: doc/BRIEF.md
# Display Fetch Priority Arbiter

This block sets the priority flag, high or low, that a display controller places on every memory fetch request it issues to the system interconnect. It does not issue the fetches. It only computes the flag from the state of the display buffers and from a 32-bit configuration register that software writes and reads back through one simple port.

Each enable bit in the register ties one buffer-status condition to high priority. The conditions cover the sync buffer, the flicker-filter buffer and the line buffers. All enabled conditions are ORed with a high-priority request that arrives from the FIFO watermark logic outside the block. A line counter restarts at each VSYNC pulse. It can hold requests at low priority for a programmed number of scan lines, so that refilling the buffers after VSYNC does not keep the interconnect at high priority. Only the line-buffer-fill condition can override this low-priority window.

A separate gate uses the fill level of the display FIFO to decide when a line-buffer load may start. Software selects one of two rules: a programmable watermark in 256-byte steps, or the FIFO being full.

Top module: `disp_fetch_prio`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cfg_rd_data` reads 0 and `req_high_prio` is 0.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data[20:0]`, and `cfg_rd_data` shows the stored value from the next cycle. Bits [31:21] always read 0. Bits 2 and 3 are stored and read back but have no effect on any output.
- R3: With bit 8 set, priority is high whenever `sb_valid` is 0.
- R4: With bit 7 set, priority is high when `fb_valid` is 0 and `sb_below_half` is 1. With bit 6 set, priority is high when `fb_valid` is 0 and `sb_reading` is 1.
- R5: With bit 5 set, priority is high whenever `fb_valid` is 0.
- R6: With bit 4 set, priority is high when any bit of `lb_valid[2:0]` is 0 while `scaler_en` is 1. While `scaler_en` is 0, only `lb_valid[0]` is checked and bits 1 and 2 are ignored.
- R7: A 1 on `fifo_wm_hp` makes priority high in every configuration, except inside the low-priority window.
- R8: A `vsync_pulse` clears a line counter, and each `line_start` adds one to it. The counter saturates at 127, starts at 127 after reset, and a VSYNC pulse takes precedence over a line strobe in the same cycle. While bit 0 is set and the counter is below field [15:9], every high-priority source from R3 to R7 is masked to low. A field value of 0 gives no window.
- R9: With bit 1 set, priority is high whenever `lb_fill_active` is 1, including inside the low-priority window.
- R10: With bit 20 set, `lb_load_ok` is 1 exactly when `fifo_level` (in bytes) is at least field [19:16] times 256. A field value of 0 always permits a load.
- R11: With bit 20 clear, `lb_load_ok` is 1 only when `fifo_level` equals the FIFO capacity, 4096 bytes by default.
- R12: `req_high_prio` is registered. It reflects the inputs and the register contents of the previous cycle, so a register write changes the priority two clock edges after the write cycle. `lb_load_ok` is combinational from the current level and register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Configuration register contents |
| vsync_pulse | input | 1 | Start-of-frame pulse, clears the line counter |
| line_start | input | 1 | Start-of-line strobe, advances the line counter |
| sb_valid | input | 1 | Sync buffer holds valid data |
| sb_below_half | input | 1 | Sync buffer is less than half full |
| sb_reading | input | 1 | Sync buffer is being read |
| fb_valid | input | 1 | Flicker-filter buffer holds valid data |
| lb_valid | input | 3 | Valid flag of each line buffer |
| scaler_en | input | 1 | Scaler filter enabled, so all line buffers are used |
| lb_fill_active | input | 1 | A line-buffer fill is in progress |
| fifo_wm_hp | input | 1 | External FIFO-watermark high-priority request |
| fifo_level | input | 13 | Display FIFO fill level in bytes |
| req_high_prio | output | 1 | Priority of outgoing fetch requests (1 = high) |
| lb_load_ok | output | 1 | A line-buffer load may start |

## Verification
The checker watches several rules on every cycle. The reserved bits must read zero, and a write must be visible in the next cycle. The line-fill condition and the external watermark request must raise priority. With every source disabled, priority must stay low. A VSYNC pulse must open the window whenever a count is programmed. With the watermark disabled, the load permit must follow the full-FIFO rule. The bench sweeps every combination of the five condition enables against every buffer-status pattern, and it sweeps the watermark field across the boundaries of each threshold. Only these sequenced scenarios can show the exact length of the window as lines are counted, the zero-count case, the window masking the external request, and the two-edge latency after a register write.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

    localparam int CFG_W  = 32;
    localparam int CNT_W  = 7;
    localparam int WM_W   = 4;
    localparam int NUM_LB = 3;

    localparam logic [CFG_W-1:0] CFG_MASK = 32'h001F_FFFF;

    typedef struct packed {
        logic [10:0]      rsvd;
        logic             wm_en;
        logic [WM_W-1:0]  wm;
        logic [CNT_W-1:0] lp_lines;
        logic             sb_inv;
        logic             fb_inv_half;
        logic             fb_inv_rd;
        logic             fb_inv;
        logic             lb_inv;
        logic [1:0]       spare;
        logic             fill;
        logic             lp_vsync;
    } cfg_t;

    typedef struct packed {
        logic sb_inv;
        logic fb_inv_half;
        logic fb_inv_rd;
        logic fb_inv;
        logic lb_inv;
        logic fill;
    } prio_en_t;

    typedef struct packed {
        logic              sb_valid;
        logic              sb_below_half;
        logic              sb_reading;
        logic              fb_valid;
        logic [NUM_LB-1:0] lb_valid;
        logic              scaler_en;
        logic              fifo_hp;
        logic              lb_fill;
    } buf_stat_t;

    function automatic logic any_lb_invalid(input logic [NUM_LB-1:0] valid,
                                            input logic scaler_on);
        logic miss;
        miss = ~valid[0];
        for (int i = 1; i < NUM_LB; i++) begin
            miss = miss | (scaler_on & ~valid[i]);
        end
        return miss;
    endfunction

endpackage

// File: rtl/dfp_cfg_reg.sv
module dfp_cfg_reg
    import dfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_t'(wr_data & CFG_MASK);
        end
    end

endmodule

// File: rtl/dfp_line_window.sv
module dfp_line_window
    import dfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vsync_pulse,
    input  logic             line_start,
    input  logic             enable,
    input  logic [CNT_W-1:0] end_count,
    output logic             lp_win
);

    logic [CNT_W-1:0] line_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '1;
        end else if (vsync_pulse) begin
            line_cnt <= '0;
        end else if (line_start && (line_cnt != '1)) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    always_comb begin
        lp_win = enable && (line_cnt < end_count);
    end

endmodule

// File: rtl/dfp_prio_logic.sv
module dfp_prio_logic
    import dfp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  prio_en_t  en,
    input  buf_stat_t st,
    input  logic      lp_win,
    output logic      prio_q
);

    logic hp_any;
    logic fill_hp;
    logic prio_d;

    always_comb begin
        hp_any = st.fifo_hp
               | (en.sb_inv      & ~st.sb_valid)
               | (en.fb_inv_half & ~st.fb_valid & st.sb_below_half)
               | (en.fb_inv_rd   & ~st.fb_valid & st.sb_reading)
               | (en.fb_inv      & ~st.fb_valid)
               | (en.lb_inv      & any_lb_invalid(st.lb_valid, st.scaler_en));
        fill_hp = en.fill & st.lb_fill;
        prio_d  = fill_hp | (hp_any & ~lp_win);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= 1'b0;
        end else begin
            prio_q <= prio_d;
        end
    end

endmodule

// File: rtl/dfp_lb_gate.sv
module dfp_lb_gate
    import dfp_pkg::*;
#(
    parameter int FIFO_BYTES = 4096,
    parameter int WM_UNIT    = 256,
    parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic             wm_en,
    input  logic [WM_W-1:0]  wm,
    input  logic [LVL_W-1:0] level,
    output logic             permit
);

    localparam int TW = LVL_W + WM_W + 1;

    logic [TW-1:0] threshold;

    always_comb begin
        threshold = TW'(wm) * TW'(WM_UNIT);
        if (wm_en) begin
            permit = TW'(level) >= threshold;
        end else begin
            permit = level == LVL_W'(FIFO_BYTES);
        end
    end

endmodule

// File: rtl/disp_fetch_prio.sv
module disp_fetch_prio
    import dfp_pkg::*;
#(
    parameter int FIFO_BYTES = 4096,
    parameter int WM_UNIT    = 256,
    parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              vsync_pulse,
    input  logic              line_start,
    input  logic              sb_valid,
    input  logic              sb_below_half,
    input  logic              sb_reading,
    input  logic              fb_valid,
    input  logic [NUM_LB-1:0] lb_valid,
    input  logic              scaler_en,
    input  logic              lb_fill_active,
    input  logic              fifo_wm_hp,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              req_high_prio,
    output logic              lb_load_ok
);

    cfg_t      cfg_q;
    prio_en_t  en;
    buf_stat_t st;
    logic      lp_win;

    dfp_cfg_reg i_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_q   (cfg_q)
    );

    assign cfg_rd_data = cfg_q;

    dfp_line_window i_win (
        .clk         (clk),
        .rst         (rst),
        .vsync_pulse (vsync_pulse),
        .line_start  (line_start),
        .enable      (cfg_q.lp_vsync),
        .end_count   (cfg_q.lp_lines),
        .lp_win      (lp_win)
    );

    always_comb begin
        en.sb_inv      = cfg_q.sb_inv;
        en.fb_inv_half = cfg_q.fb_inv_half;
        en.fb_inv_rd   = cfg_q.fb_inv_rd;
        en.fb_inv      = cfg_q.fb_inv;
        en.lb_inv      = cfg_q.lb_inv;
        en.fill        = cfg_q.fill;

        st.sb_valid      = sb_valid;
        st.sb_below_half = sb_below_half;
        st.sb_reading    = sb_reading;
        st.fb_valid      = fb_valid;
        st.lb_valid      = lb_valid;
        st.scaler_en     = scaler_en;
        st.fifo_hp       = fifo_wm_hp;
        st.lb_fill       = lb_fill_active;
    end

    dfp_prio_logic i_prio (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .st     (st),
        .lp_win (lp_win),
        .prio_q (req_high_prio)
    );

    dfp_lb_gate #(
        .FIFO_BYTES (FIFO_BYTES),
        .WM_UNIT    (WM_UNIT),
        .LVL_W      (LVL_W)
    ) i_gate (
        .wm_en  (cfg_q.wm_en),
        .wm     (cfg_q.wm),
        .level  (fifo_level),
        .permit (lb_load_ok)
    );

endmodule

// File: rtl/dfp_checker.sv
module dfp_checker #(
    parameter int FIFO_BYTES = 4096,
    parameter int LVL_W      = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_en,
    input logic [31:0]      cfg_wr_data,
    input logic [31:0]      cfg_rd_data,
    input logic             vsync_pulse,
    input logic             lb_fill_active,
    input logic             fifo_wm_hp,
    input logic [LVL_W-1:0] fifo_level,
    input logic             lp_win,
    input logic             req_high_prio,
    input logic             lb_load_ok
);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[31:21] == 11'd0);

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |=> cfg_rd_data == ($past(cfg_wr_data) & 32'h001F_FFFF));

    p_fill_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[1] && lb_fill_active) |=> req_high_prio);

    p_wm_hp_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_wm_hp && !lp_win) |=> req_high_prio);

    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[8:4] == 5'd0 && !cfg_rd_data[1] && !fifo_wm_hp) |=> !req_high_prio);

    p_window_opens_r8: assert property (@(posedge clk) disable iff (rst)
        (vsync_pulse && cfg_rd_data[0] && cfg_rd_data[15:9] != 7'd0 && !cfg_wr_en) |=> lp_win);

    p_full_permit_r11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rd_data[20] && fifo_level == LVL_W'(FIFO_BYTES)) |-> lb_load_ok);

    p_not_full_r11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rd_data[20] && fifo_level != LVL_W'(FIFO_BYTES)) |-> !lb_load_ok);

endmodule

bind disp_fetch_prio dfp_checker #(
    .FIFO_BYTES (FIFO_BYTES),
    .LVL_W      (LVL_W)
) i_dfp_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_data    (cfg_wr_data),
    .cfg_rd_data    (cfg_rd_data),
    .vsync_pulse    (vsync_pulse),
    .lb_fill_active (lb_fill_active),
    .fifo_wm_hp     (fifo_wm_hp),
    .fifo_level     (fifo_level),
    .lp_win         (lp_win),
    .req_high_prio  (req_high_prio),
    .lb_load_ok     (lb_load_ok)
);

// File: tb/test_disp_fetch_prio.sv
module test_disp_fetch_prio;

    localparam int CLK_NS = 20;
    localparam int FIFO_B = 4096;
    localparam int LVL_W  = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic vsync_pulse = 1'b0, line_start = 1'b0;
    logic sb_valid = 1'b1, sb_below_half = 1'b0, sb_reading = 1'b0, fb_valid = 1'b1;
    logic [2:0] lb_valid = 3'b111;
    logic scaler_en = 1'b0, lb_fill_active = 1'b0, fifo_wm_hp = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic req_high_prio, lb_load_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] cfg_m = '0;
    logic [6:0]  cnt_m = 7'h7F;

    always #(CLK_NS/2) clk = ~clk;

    disp_fetch_prio i_disp_fetch_prio (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .vsync_pulse(vsync_pulse), .line_start(line_start),
        .sb_valid(sb_valid), .sb_below_half(sb_below_half), .sb_reading(sb_reading),
        .fb_valid(fb_valid), .lb_valid(lb_valid), .scaler_en(scaler_en),
        .lb_fill_active(lb_fill_active), .fifo_wm_hp(fifo_wm_hp),
        .fifo_level(fifo_level), .req_high_prio(req_high_prio), .lb_load_ok(lb_load_ok)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_prio();
        logic hp, lbmiss, win;
        lbmiss = scaler_en ? (lb_valid != 3'b111) : !lb_valid[0];
        hp = fifo_wm_hp
           | (cfg_m[8] & !sb_valid)
           | (cfg_m[7] & !fb_valid & sb_below_half)
           | (cfg_m[6] & !fb_valid & sb_reading)
           | (cfg_m[5] & !fb_valid)
           | (cfg_m[4] & lbmiss);
        win = cfg_m[0] && (cnt_m < cfg_m[15:9]);
        return (cfg_m[1] & lb_fill_active) | (hp & !win);
    endfunction

    // Called at a falling edge with inputs already driven.
    task automatic step(input string tag);
        logic exp_p;
        exp_p = model_prio();
        @(posedge clk);
        if (cfg_wr_en) cfg_m = cfg_wr_data & 32'h001F_FFFF;
        if (vsync_pulse) cnt_m = 7'd0;
        else if (line_start && cnt_m != 7'h7F) cnt_m = cnt_m + 7'd1;
        @(negedge clk);
        check(tag, {31'd0, req_high_prio}, {31'd0, exp_p});
        cfg_wr_en = 1'b0;
        vsync_pulse = 1'b0;
        line_start = 1'b0;
    endtask

    task automatic write_cfg(input logic [31:0] v, input string tag);
        cfg_wr_en = 1'b1;
        cfg_wr_data = v;
        step(tag);
        check({tag, " readback"}, cfg_rd_data, v & 32'h001F_FFFF);
    endtask

    task automatic set_idle();
        sb_valid = 1'b1; sb_below_half = 1'b0; sb_reading = 1'b0; fb_valid = 1'b1;
        lb_valid = 3'b111; scaler_en = 1'b0; lb_fill_active = 1'b0; fifo_wm_hp = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 cfg in reset", cfg_rd_data, 32'd0);
        check("R1 prio in reset", {31'd0, req_high_prio}, 32'd0);
        fifo_wm_hp = 1'b1;
        rst = 1'b0;
        check("R1 cfg after reset", cfg_rd_data, 32'd0);
        check("R1 prio after reset", {31'd0, req_high_prio}, 32'd0);
        check("R11 permit at level 0", {31'd0, lb_load_ok}, 32'd0);
        step("R7 external request");
        set_idle();
        step("R7 external request released");

        // R2 reserved bits and write visibility
        write_cfg(32'hFFFF_FFFF, "R2 all ones");
        write_cfg(32'h0000_000C, "R2 spare bits only");
        sb_valid = 1'b0; fb_valid = 1'b0; lb_valid = 3'b000;
        step("R2 spare bits have no effect");
        set_idle();

        // R12 latency after a write
        sb_valid = 1'b0;
        write_cfg(32'h0000_0100, "R12 write cycle keeps old priority");
        step("R12 R3 priority after write");
        set_idle();

        // R3 R4 R5 R6 R7 exhaustive sweep
        for (int c = 0; c < 32; c++) begin
            set_idle();
            write_cfg((32'(c) << 4) | 32'h0000_000C, "R2 sweep cfg");
            for (int p = 0; p < 512; p++) begin
                sb_valid      = p[0];
                sb_below_half = p[1];
                sb_reading    = p[2];
                fb_valid      = p[3];
                lb_valid      = p[6:4];
                scaler_en     = p[7];
                fifo_wm_hp    = p[8];
                step("R3/R4/R5/R6/R7 sweep");
            end
        end

        // R8 window after VSYNC, three lines
        set_idle();
        fb_valid = 1'b0;
        write_cfg(32'h0000_0021 | (32'd3 << 9), "R8 window cfg");
        step("R8 before vsync");
        vsync_pulse = 1'b1;
        step("R8 vsync cycle");
        step("R8 window line 0");
        for (int k = 0; k < 3; k++) begin
            line_start = 1'b1;
            step("R8 counting lines");
        end
        step("R8 window closed");
        fifo_wm_hp = 1'b1;
        vsync_pulse = 1'b1;
        line_start = 1'b1;
        step("R8 vsync beats line strobe");
        step("R7 R8 external request masked");
        line_start = 1'b1;
        step("R8 one line");

        // R9 fill condition overrides window
        write_cfg(32'h0000_0023 | (32'd5 << 9), "R9 cfg");
        vsync_pulse = 1'b1;
        step("R9 vsync");
        step("R9 window masks");
        lb_fill_active = 1'b1;
        step("R9 fill wins in window");
        lb_fill_active = 1'b0;
        step("R9 fill released");

        // R8 zero count gives no window
        write_cfg(32'h0000_0021, "R8 zero count cfg");
        vsync_pulse = 1'b1;
        step("R8 zero count vsync");
        step("R8 zero count no window");
        set_idle();
        step("R8 idle");

        // R10 R11 load permit sweep
        for (int e = 0; e < 2; e++) begin
            for (int w = 0; w < 16; w++) begin
                write_cfg((32'(e) << 20) | (32'(w) << 16), "R10 gate cfg");
                for (int j = 0; j < 6; j++) begin
                    int lv;
                    logic ex;
                    case (j)
                        0: lv = 0;
                        1: lv = (w == 0) ? 1 : w * 256 - 1;
                        2: lv = w * 256;
                        3: lv = w * 256 + 1;
                        4: lv = FIFO_B - 1;
                        default: lv = FIFO_B;
                    endcase
                    fifo_level = LVL_W'(lv);
                    #2;
                    ex = (e == 1) ? (lv >= w * 256) : (lv == FIFO_B);
                    check((e == 1) ? "R10 watermark permit" : "R11 full permit",
                          {31'd0, lb_load_ok}, {31'd0, ex});
                end
                @(negedge clk);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule